// File: doc/BRIEF.md
# Transmit Jabber Lockout and Heartbeat Supervisor

This block supervises the transmit side of a coaxial network attachment. It watches a single transmit-active flag from the line receiver. A transmission that stays active too long is treated as a runaway station. The block then forces its transmit enable low and raises a collision report. The lockout is held until the input has stayed idle for a complete reset period. If activity reappears during that idle period, the period starts over.

When a transmission ends normally and heartbeat is enabled, the block raises a short collision-presence burst. The burst starts a fixed delay after the end of the packet. No burst follows a transmission that the lockout cut off.

A two-bit mode input carries the already-decoded three-level control pin. Its settings are heartbeat on, heartbeat off, and a test setting that disables the lockout. After the test setting is left, the lockout stays disabled for one full reset period. The collision report gates a square wave at half the clock rate, which is 10 MHz from a 20 MHz clock. All time windows are counts of clock cycles and are set by parameters.

Top module: `jabber_hb_ctrl`

## Requirements
- R1: While reset is held, tx_en_o follows tx_active_i and both col_req_o and col_o are 0.
- R2: The lockout engages after JAB_CYC consecutive clock edges that sample tx_active_i high while the lockout is armed. From the next cycle, tx_en_o is 0 even while tx_active_i is 1.
- R3: While the lockout is engaged, col_req_o is 1 and col_o toggles every clock cycle.
- R4: The lockout releases after RST_CYC consecutive edges that sample tx_active_i low. Any edge that samples tx_active_i high restarts that count.
- R5: In mode 2'b00, a transmission that ends without lockout makes col_req_o high for exactly HB_LEN cycles. The first high cycle follows the (HB_DLY+1)-th edge after tx_active_i falls.
- R6: No heartbeat is produced in mode 2'b01. No heartbeat is produced after a transmission during which the lockout engaged.
- R7: In test mode (mode_i[1] = 1), the lockout never engages and no heartbeat is produced. Active bursts of any length leave tx_en_o equal to tx_active_i.
- R8: After mode_i[1] returns to 0, the lockout stays disarmed for RST_CYC clock edges. A burst that falls inside that window does not engage it.
- R9: col_o is 0 in every cycle where col_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, nominally 20 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | Transmit data present on the attachment interface |
| mode_i | input | 2 | 00 heartbeat on, 01 heartbeat off, 1x test (lockout disabled) |
| tx_en_o | output | 1 | Enables the line transmitter |
| col_req_o | output | 1 | Collision report requested (lockout or heartbeat) |
| col_o | output | 1 | col_req_o gated with the half-rate square wave |

## Verification
The lockout and the end-of-packet heartbeat can meet in one cycle. This happens when a burst lasts exactly JAB_CYC cycles: the edge that engages the lockout is the last edge that samples the burst high, so the falling transmit flag is first seen while the lockout is already set. The bench sweeps burst lengths from one cycle up past JAB_CYC in both heartbeat modes. For each length it predicts arithmetically whether a heartbeat window or a lockout window should follow, and checks col_req_o and tx_en_o cycle by cycle. Lengths JAB_CYC-1 and JAB_CYC are the decisive pair: the first must produce a heartbeat, the second a lockout with no heartbeat.

// File: rtl/jhb_pkg.sv
package jhb_pkg;
  typedef enum logic [1:0] {
    MODE_HB_ON  = 2'b00,
    MODE_HB_OFF = 2'b01,
    MODE_TEST   = 2'b10,
    MODE_TEST_X = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    HB_IDLE = 2'b00,
    HB_WAIT = 2'b01,
    HB_ON   = 2'b10
  } hb_st_e;
endpackage

// File: rtl/jhb_osc.sv
module jhb_osc #(
  parameter int HALF = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic osc_o
);
  logic osc_q;

  generate
    if (HALF == 1) begin : g_toggle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) osc_q <= 1'b0;
        else         osc_q <= ~osc_q;
      end
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
          osc_q <= 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
          osc_q <= ~osc_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  endgenerate

  assign osc_o = osc_q;
endmodule

// File: rtl/jhb_jabber.sv
module jhb_jabber #(
  parameter int JAB_CYC = 520000,
  parameter int RST_CYC = 8400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  input  logic test_i,
  output logic lock_o
);
  localparam int JW = $clog2(JAB_CYC + 1);
  localparam int RW = $clog2(RST_CYC + 1);

  logic [JW-1:0] run_q;
  logic [RW-1:0] quiet_q;
  logic [RW-1:0] guard_q;
  logic          lock_q;
  logic          armed;

  assign armed = !test_i && (guard_q == '0);

  // guard holds jabber off for a full reset time after test mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             guard_q <= '0;
    else if (test_i)         guard_q <= RW'(RST_CYC);
    else if (guard_q != '0)  guard_q <= guard_q - RW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      run_q   <= '0;
      quiet_q <= '0;
    end else if (!armed) begin
      lock_q  <= 1'b0;
      run_q   <= '0;
      quiet_q <= '0;
    end else if (lock_q) begin
      run_q <= '0;
      if (tx_active_i) begin
        quiet_q <= '0;
      end else if (quiet_q == RW'(RST_CYC - 1)) begin
        lock_q  <= 1'b0;
        quiet_q <= '0;
      end else begin
        quiet_q <= quiet_q + RW'(1);
      end
    end else begin
      quiet_q <= '0;
      if (!tx_active_i) begin
        run_q <= '0;
      end else if (run_q == JW'(JAB_CYC - 1)) begin
        lock_q <= 1'b1;
        run_q  <= '0;
      end else begin
        run_q <= run_q + JW'(1);
      end
    end
  end

  assign lock_o = lock_q;

  // R2
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(tx_active_i));

  // R4
  unlock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock_q) && !$past(test_i)) |-> !$past(tx_active_i));

  // R8
  guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> ($past(guard_q) == '0 && !$past(test_i)));
endmodule

// File: rtl/jhb_heartbeat.sv
module jhb_heartbeat
  import jhb_pkg::*;
#(
  parameter int HB_DLY = 22,
  parameter int HB_LEN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic hb_o
);
  localparam int MAXC = (HB_DLY > HB_LEN) ? HB_DLY : HB_LEN;
  localparam int CW   = $clog2(MAXC + 1);

  hb_st_e        st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HB_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      st_q  <= HB_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        HB_WAIT: begin
          if (cnt_q == CW'(HB_DLY - 1)) begin
            st_q  <= HB_ON;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        HB_ON: begin
          if (cnt_q == CW'(HB_LEN - 1)) begin
            st_q  <= HB_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign hb_o = (st_q == HB_ON);

  // burst length monitor
  logic [CW:0] hb_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hb_run_q <= '0;
    else if (!hb_o)                      hb_run_q <= '0;
    else if (hb_run_q <= (CW+1)'(HB_LEN)) hb_run_q <= hb_run_q + (CW+1)'(1);
  end

  // R5
  hb_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_run_q <= (CW+1)'(HB_LEN));
endmodule

// File: rtl/jabber_hb_ctrl.sv
module jabber_hb_ctrl
  import jhb_pkg::*;
#(
  parameter int JAB_CYC  = 520000,
  parameter int RST_CYC  = 8400000,
  parameter int HB_DLY   = 22,
  parameter int HB_LEN   = 20,
  parameter int OSC_HALF = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_active_i,
  input  logic [1:0] mode_i,
  output logic       tx_en_o,
  output logic       col_req_o,
  output logic       col_o
);
  logic test_mode;
  logic hb_enable;
  logic lock;
  logic hb;
  logic osc;
  logic tx_q;
  logic hb_start;

  assign test_mode = mode_i[1];
  assign hb_enable = (mode_i == MODE_HB_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= 1'b0;
    else         tx_q <= tx_active_i;
  end

  // end of a packet that was not cut off
  assign hb_start = tx_q && !tx_active_i && !lock && hb_enable;

  jhb_jabber #(
    .JAB_CYC (JAB_CYC),
    .RST_CYC (RST_CYC)
  ) u_jabber (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .test_i      (test_mode),
    .lock_o      (lock)
  );

  jhb_heartbeat #(
    .HB_DLY (HB_DLY),
    .HB_LEN (HB_LEN)
  ) u_hb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (hb_start),
    .hb_o    (hb)
  );

  jhb_osc #(
    .HALF (OSC_HALF)
  ) u_osc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .osc_o  (osc)
  );

  assign tx_en_o   = tx_active_i && !lock;
  assign col_req_o = lock || hb;
  assign col_o     = col_req_o && osc;
endmodule

// File: tb/jabber_hb_ctrl_tb.sv
module jabber_hb_ctrl_tb;
  localparam int JAB = 20;
  localparam int RST = 30;
  localparam int DLY = 4;
  localparam int LEN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tx_en, col_req, col;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  jabber_hb_ctrl #(
    .JAB_CYC (JAB), .RST_CYC (RST), .HB_DLY (DLY), .HB_LEN (LEN), .OSC_HALF (1)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .tx_active_i (tx), .mode_i (mode),
    .tx_en_o (tx_en), .col_req_o (col_req), .col_o (col)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // burst of n active cycles followed by an observation window
  task automatic burst(input int n, input logic [1:0] m, input bit exp_lock);
    int win;
    logic prev_col;
    bit exp_c;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tx = 1'b1; mode = m;
      #1;
      chk(tx_en == (!exp_lock || k < JAB), "R2/R7 tx_en in burst", tx_en, (!exp_lock || k < JAB));
      chk(col_req == (exp_lock && k >= JAB), "R3 col_req in burst", col_req, (exp_lock && k >= JAB));
    end
    win = exp_lock ? RST + DLY + LEN + 4 : DLY + LEN + 4;
    prev_col = col;
    for (int j = 0; j < win; j++) begin
      @(negedge clk); tx = 1'b0;
      #1;
      if (exp_lock) begin
        exp_c = (j < RST);
        chk(col_req == exp_c, "R4/R6 lock window", col_req, exp_c);
        if (exp_c && j > 0) chk(col != prev_col, "R3 col toggle", col, !prev_col);
      end else begin
        exp_c = (m == 2'b00) && (j >= DLY + 1) && (j <= DLY + LEN);
        chk(col_req == exp_c, "R5/R6/R7 heartbeat window", col_req, exp_c);
      end
      if (!exp_c) chk(col == 1'b0, "R9 col idle", col, 0);
      prev_col = col;
    end
  endtask

  initial begin
    #1;
    tx = 1'b1;
    #5;
    chk(tx_en == 1'b1, "R1 tx_en in reset", tx_en, 1);
    chk(col_req == 1'b0, "R1 col_req in reset", col_req, 0);
    chk(col == 1'b0, "R1 col in reset", col, 0);
    tx = 1'b0;
    #50 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep burst lengths in both heartbeat modes, straddling JAB
    for (int md = 0; md < 2; md++) begin
      for (int n = 1; n <= JAB + 3; n++) begin
        burst(n, 2'(md), n >= JAB);
      end
    end

    // R4 restart of the quiet count
    for (int k = 0; k < JAB + 2; k++) begin
      @(negedge clk); tx = 1'b1; mode = 2'b00;
    end
    for (int j = 0; j < RST - 2; j++) begin
      @(negedge clk); tx = 1'b0;
      #1 chk(col_req == 1'b1, "R4 lock before restart", col_req, 1);
    end
    @(negedge clk); tx = 1'b1;
    #1 chk(tx_en == 1'b0, "R4 tx_en held during lock", tx_en, 0);
    for (int j = 0; j < RST + DLY + LEN + 4; j++) begin
      @(negedge clk); tx = 1'b0;
      #1 chk(col_req == (j < RST), "R4 restarted quiet count", col_req, (j < RST));
    end

    // R7 test modes: no lock, no heartbeat
    burst(JAB + 5, 2'b10, 1'b0);
    burst(JAB + 5, 2'b11, 1'b0);
    // R8 guard right after leaving test mode
    burst(JAB + 2, 2'b00, 1'b0);
    repeat (RST) @(negedge clk);
    burst(JAB, 2'b00, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule